// File: doc/BRIEF.md
# UART Register Front End

This block is the bus side of a serial port. Software reaches it through a single-beat 32-bit register port with five word registers. Behind that port sit two 64-byte FIFOs, one for each direction. On the line side the block connects to a serializer and a deserializer, which are separate blocks. The transmit FIFO hands bytes to the serializer with a valid/ready handshake. The deserializer pushes each received byte together with a frame-error flag and a parity-error flag.

The block stores the control word and exports it whole, so the serializer, baud generator and pin-polarity logic can take their settings from it. It keeps sticky error flags and reports FIFO occupancy. It drives a transmit interrupt and a receive interrupt, each from its own programmable count threshold.

A driver brings the port up with one control write. That write flushes both FIFOs, clears the error flags and sets the enables. The driver then feeds the transmit FIFO up to its free space, which is 64 minus the transmit count, or zero while the full flag is set. It drains the receive FIFO while the status register reports it non-empty.

Top module: `uart_regfront`

## Requirements
- R1: Register byte offsets, decoded from `bus_addr`:
  - 0x00 is the transmit data register (write only).
  - 0x04 is the receive data register (read only).
  - 0x08 is the control register.
  - 0x0C is the status register.
  - 0x10 is the threshold register, with the transmit threshold in [15:8] and the receive threshold in [7:0].
  - Data registers carry their byte in [7:0], and the upper bits read as zero.
  - The threshold register reads back its low 16 bits and returns zero above them.
- R2: Each FIFO holds 64 bytes and delivers them in the order they were accepted. Status bits:
  - [14:8] is the transmit count and [6:0] is the receive count.
  - Bit 22 is transmit empty and bit 21 is transmit full.
  - Bit 20 is receive empty and bit 19 is receive full.
- R3: A transmit data write while the transmit FIFO is full discards the byte and leaves the count unchanged. It also sets the sticky write-while-full flag, status bit 18.
- R4: A received byte that arrives while the receive FIFO is full is discarded and sets the sticky overflow flag, status bit 24.
- R5: A read of the receive data register returns the oldest byte and removes it from the FIFO. A read while the FIFO is empty returns zero and changes nothing.
- R6: Three control bits act as one-shot commands and always read back as zero:
  - Bit 22 empties the transmit FIFO.
  - Bit 23 empties the receive FIFO.
  - Bit 24 clears status bits 24, 18, 17 and 16.
- R7: The control register reads back the last value written, with bits 24:22 and bit 14 forced to zero. The same value drives `cfg_word`. Other control fields:
  - [21:20] is the character length: 00 for 8 bits, 01 for 7, 10 for 6, 11 for 5.
  - Bit 19 enables parity and bit 18 selects odd parity.
  - [17:16] sets the stop bits: 00 for one, 01 for two.
- R8: A byte that is received while reception is enabled and that carries a frame error sets the sticky flag at status bit 17. A parity error sets the sticky flag at status bit 16. Neither flag is set while the error mask, control bit 30, is 1.
- R9: `irq_rx` is high when control bit 27 is 1, the receive threshold is nonzero, and the receive count is at least that threshold.
- R10: `irq_tx` is high when control bit 28 is 1 and the transmit count is at most the transmit threshold.
- R11: `tx_valid` is high only while control bit 12 (transmit enable) is 1 and the transmit FIFO holds data. Received bytes are ignored while control bit 13 (receive enable) is 0.
- R12: Status bit 23 follows `line_cts`, bit 25 follows `line_tx_busy` and bit 26 follows `line_rx_busy`. All unused status bits read as zero.
- R13: After reset the following hold:
  - The control and threshold registers are zero.
  - Both FIFOs are empty and all sticky flags are clear.
  - Both interrupts are low.
- R14: Register reads return their data on `bus_rdata` one cycle after the request cycle, and the value reflects the state before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte on this edge |
| rx_data | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | Received byte push, one cycle per byte |
| rx_frame_err | input | 1 | Frame error for the pushed byte |
| rx_parity_err | input | 1 | Parity error for the pushed byte |
| line_cts | input | 1 | Clear-to-send level |
| line_tx_busy | input | 1 | Serializer busy |
| line_rx_busy | input | 1 | Deserializer busy |
| cfg_word | output | 32 | Stored control word for line-side logic |
| irq_tx | output | 1 | Transmit threshold interrupt |
| irq_rx | output | 1 | Receive threshold interrupt |

## Verification
Each register access takes effect at the edge that closes its request cycle. Read data appears on `bus_rdata` at that same edge, so the bench drives inputs shortly after a rising edge and samples the read word once the next edge has settled. FIFO counts, sticky flags and both interrupts change at the edge of the causing write or push, so the bench checks them in the cycle straight after. A transmit byte leaves on the edge where `tx_valid` and `tx_ready` are both high. The bench's monitor compares it against the front of an expected queue at the falling edge before that rising edge.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_TXD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RXD = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STA = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_THR = 5'h10;

  // control bit positions used by this block
  localparam int unsigned CB_TX_EN   = 12;
  localparam int unsigned CB_RX_EN   = 13;
  localparam int unsigned CB_TX_CLR  = 22;
  localparam int unsigned CB_RX_CLR  = 23;
  localparam int unsigned CB_ERR_CLR = 24;
  localparam int unsigned CB_RX_IE   = 27;
  localparam int unsigned CB_TX_IE   = 28;
  localparam int unsigned CB_ERR_MSK = 30;

  // bits kept in the control register: command bits 24:22 and bit 14 dropped
  localparam logic [31:0] CTL_KEEP = 32'hFE3F_BFFF;

  typedef struct packed {
    logic       rx_busy;
    logic       tx_busy;
    logic       rx_ovf;
    logic       cts;
    logic       tx_empty;
    logic       tx_full;
    logic       rx_empty;
    logic       rx_full;
    logic       wr_full;
    logic       frame_err;
    logic       par_err;
    logic [6:0] tx_cnt;
    logic [6:0] rx_cnt;
  } status_t;

  function automatic logic [31:0] pack_status(input status_t s);
    logic [31:0] w;
    w        = '0;
    w[26]    = s.rx_busy;
    w[25]    = s.tx_busy;
    w[24]    = s.rx_ovf;
    w[23]    = s.cts;
    w[22]    = s.tx_empty;
    w[21]    = s.tx_full;
    w[20]    = s.rx_empty;
    w[19]    = s.rx_full;
    w[18]    = s.wr_full;
    w[17]    = s.frame_err;
    w[16]    = s.par_err;
    w[14:8]  = s.tx_cnt;
    w[6:0]   = s.rx_cnt;
    return w;
  endfunction

  function automatic logic rx_level_hit(input logic [7:0] cnt, input logic [7:0] thr);
    return (thr != 8'd0) && (cnt >= thr);
  endfunction

  function automatic logic tx_level_hit(input logic [7:0] cnt, input logic [7:0] thr);
    return cnt <= thr;
  endfunction

  // sticky flag update: a new event in the same cycle wins over a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return (q & ~clr) | set;
  endfunction

endpackage

// File: rtl/urf_byte_fifo.sv
module urf_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_drop
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full      = (cnt_q == CMAX);
  assign empty     = (cnt_q == '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign dout      = mem[rp_q];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6: a flush leaves the FIFO empty on the next cycle
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R3/R4: a push into a full FIFO without a pop does not grow it
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == CMAX));

  // R2: occupancy never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CMAX);

endmodule

// File: rtl/urf_irq_gen.sv
module urf_irq_gen #(
  parameter int unsigned CW = 7
) (
  input  logic          rx_ie,
  input  logic          tx_ie,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [7:0]    rx_thr,
  input  logic [7:0]    tx_thr,
  output logic          irq_rx,
  output logic          irq_tx
);
  import uart_regfront_pkg::*;

  assign irq_rx = rx_ie && rx_level_hit(8'(rx_cnt), rx_thr);
  assign irq_tx = tx_ie && tx_level_hit(8'(tx_cnt), tx_thr);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_frame_err,
  input  logic        rx_parity_err,
  input  logic        line_cts,
  input  logic        line_tx_busy,
  input  logic        line_rx_busy,
  output logic [31:0] cfg_word,
  output logic        irq_tx,
  output logic        irq_rx
);
  import uart_regfront_pkg::*;

  // decoded access events
  logic wr_txd, rd_rxd, wr_ctl, wr_thr, rd_any;
  logic tx_flush, rx_flush, err_clr;
  logic rx_take, tx_take;

  logic [31:0] ctl_q;
  logic [15:0] thr_q;
  logic [31:0] rdata_q;
  logic        wwf_q, ovf_q, frm_q, par_q;

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_drop, rx_drop;
  logic [7:0]    rx_head;
  logic          frm_set, par_set;
  status_t       sta;

  assign wr_txd   = bus_sel &&  bus_we && (bus_addr == OFS_TXD);
  assign rd_rxd   = bus_sel && !bus_we && (bus_addr == OFS_RXD);
  assign wr_ctl   = bus_sel &&  bus_we && (bus_addr == OFS_CTL);
  assign wr_thr   = bus_sel &&  bus_we && (bus_addr == OFS_THR);
  assign rd_any   = bus_sel && !bus_we;

  assign tx_flush = wr_ctl && bus_wdata[CB_TX_CLR];
  assign rx_flush = wr_ctl && bus_wdata[CB_RX_CLR];
  assign err_clr  = wr_ctl && bus_wdata[CB_ERR_CLR];

  assign tx_valid = ctl_q[CB_TX_EN] && !tx_empty;
  assign tx_take  = tx_valid && tx_ready;
  assign rx_take  = rx_valid && ctl_q[CB_RX_EN];

  assign frm_set  = rx_take && rx_frame_err  && !ctl_q[CB_ERR_MSK];
  assign par_set  = rx_take && rx_parity_err && !ctl_q[CB_ERR_MSK];

  urf_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (wr_txd),
    .din       (bus_wdata[7:0]),
    .pop       (tx_take),
    .dout      (tx_data),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_drop (tx_drop)
  );

  urf_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_take),
    .din       (rx_data),
    .pop       (rd_rxd),
    .dout      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_drop (rx_drop)
  );

  urf_irq_gen #(.CW(CW)) u_irq (
    .rx_ie  (ctl_q[CB_RX_IE]),
    .tx_ie  (ctl_q[CB_TX_IE]),
    .rx_cnt (rx_cnt),
    .tx_cnt (tx_cnt),
    .rx_thr (thr_q[7:0]),
    .tx_thr (thr_q[15:8]),
    .irq_rx (irq_rx),
    .irq_tx (irq_tx)
  );

  always_comb begin
    sta           = '0;
    sta.rx_busy   = line_rx_busy;
    sta.tx_busy   = line_tx_busy;
    sta.rx_ovf    = ovf_q;
    sta.cts       = line_cts;
    sta.tx_empty  = tx_empty;
    sta.tx_full   = tx_full;
    sta.rx_empty  = rx_empty;
    sta.rx_full   = rx_full;
    sta.wr_full   = wwf_q;
    sta.frame_err = frm_q;
    sta.par_err   = par_q;
    sta.tx_cnt    = 7'(tx_cnt);
    sta.rx_cnt    = 7'(rx_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      thr_q <= '0;
      wwf_q <= 1'b0;
      ovf_q <= 1'b0;
      frm_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata & CTL_KEEP;
      if (wr_thr) thr_q <= bus_wdata[15:0];
      wwf_q <= sticky_next(wwf_q, tx_drop, err_clr);
      ovf_q <= sticky_next(ovf_q, rx_drop, err_clr);
      frm_q <= sticky_next(frm_q, frm_set, err_clr);
      par_q <= sticky_next(par_q, par_set, err_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_any) begin
      case (bus_addr)
        OFS_RXD: rdata_q <= rx_empty ? 32'd0 : {24'd0, rx_head};
        OFS_CTL: rdata_q <= ctl_q;
        OFS_STA: rdata_q <= pack_status(sta);
        OFS_THR: rdata_q <= {16'd0, thr_q};
        default: rdata_q <= 32'd0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign cfg_word  = ctl_q;

  // R3: write-while-full flag stays set until a clear command
  p_sticky_wwf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wwf_q && !err_clr) |=> wwf_q);

  // R4: overflow flag stays set until a clear command
  p_sticky_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !err_clr) |=> ovf_q);

  // R5: a read of an empty receive FIFO returns zero
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && rx_empty) |=> (bus_rdata == 32'd0));

  // R11: with reception disabled a pushed byte leaves the count alone
  p_rx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctl_q[CB_RX_EN] && !rd_rxd && !rx_flush) |=> $stable(rx_cnt));

  // R11: the serializer is offered a byte only when one is held
  p_tx_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_cnt != '0));

  // R9: a zero receive threshold never raises the receive interrupt
  p_rx_thr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q[7:0] == 8'd0) |-> !irq_rx);

endmodule

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;

  localparam int unsigned CLK_PERIOD = 10;

  localparam logic [31:0] CTL_BASE = 32'h0019_3123;
  localparam logic [31:0] B_TXCLR  = 32'h0040_0000;
  localparam logic [31:0] B_RXCLR  = 32'h0080_0000;
  localparam logic [31:0] B_ERRCLR = 32'h0100_0000;
  localparam logic [31:0] B_RXIE   = 32'h0800_0000;
  localparam logic [31:0] B_TXIE   = 32'h1000_0000;
  localparam logic [31:0] B_MASK   = 32'h4000_0000;
  localparam logic [31:0] ST_IDLE  = 32'h0050_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
  logic        line_cts = 1'b0, line_tx_busy = 1'b0, line_rx_busy = 1'b0;
  logic [31:0] cfg_word;
  logic        irq_tx, irq_rx;

  int n_chk = 0;
  int n_fail = 0;
  int n_sent = 0;
  bit done = 1'b0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .line_cts(line_cts),
    .line_tx_busy(line_tx_busy), .line_rx_busy(line_rx_busy),
    .cfg_word(cfg_word), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // inputs change 2 time units after a rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    step();
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    step();
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    step();
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // driver: transmit byte, expected item queued when the FIFO can take it
  task automatic tx_put(input logic [7:0] b, input bit accepted);
    if (accepted) tx_exp.push_back(b);
    bus_write(5'h00, {24'd0, b});
  endtask

  task automatic rx_put(input logic [7:0] b, input bit fe, input bit pe);
    step();
    rx_valid = 1'b1; rx_data = b; rx_frame_err = fe; rx_parity_err = pe;
    step();
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
  endtask

  task automatic rx_get_check(input string tag);
    logic [31:0] d;
    logic [7:0]  e;
    e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'h00;
    bus_read(5'h04, d);
    chk_eq(tag, d, {24'd0, e});
  endtask

  task automatic status_is(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(5'h0C, d);
    chk_eq(tag, d, exp);
  endtask

  // monitor: a byte leaves on the next rising edge when valid and ready are high
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_exp.size() == 0) begin
        chk(1'b0, "R2 unexpected tx byte", {24'd0, tx_data}, 32'd0);
      end else begin
        chk_eq("R2 tx byte order", {24'd0, tx_data}, {24'd0, tx_exp.pop_front()});
      end
      n_sent++;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R13 reset state
    bus_read(5'h08, d);  chk_eq("R13 ctl reset", d, 32'd0);
    bus_read(5'h10, d);  chk_eq("R13 thr reset", d, 32'd0);
    status_is("R13 status reset", ST_IDLE);
    chk_eq("R13 irq reset", {30'd0, irq_tx, irq_rx}, 32'd0);

    // R7/R6 control readback with command bits and bit 14 set
    bus_write(5'h08, CTL_BASE | B_TXCLR | B_RXCLR | B_ERRCLR | 32'h0000_4000);
    bus_read(5'h08, d);  chk_eq("R7 R6 ctl readback", d, CTL_BASE);
    chk_eq("R7 cfg_word", cfg_word, CTL_BASE);

    // R2 small stream held, then released
    tx_put(8'hA5, 1'b1); tx_put(8'h3C, 1'b1); tx_put(8'h7E, 1'b1);
    status_is("R2 tx count 3", 32'h0010_0300);
    step(); tx_ready = 1'b1;
    repeat (6) step();
    tx_ready = 1'b0;
    chk_eq("R2 tx bytes sent", n_sent, 3);
    status_is("R2 tx drained", ST_IDLE);

    // R3 fill to 64, then write while full
    for (int i = 0; i < 64; i++) tx_put(8'(i + 8'h40), 1'b1);
    status_is("R2 tx full", 32'h0030_4000);
    tx_put(8'hEE, 1'b0);
    status_is("R3 write while full", 32'h0034_4000);
    bus_write(5'h08, CTL_BASE | B_TXCLR);
    tx_exp.delete();
    status_is("R6 tx flush keeps sticky", 32'h0054_0000);
    bus_write(5'h08, CTL_BASE | B_ERRCLR);
    status_is("R6 error clear", ST_IDLE);

    // R5 receive order and empty read
    rx_exp.push_back(8'h11); rx_put(8'h11, 1'b0, 1'b0);
    rx_exp.push_back(8'h22); rx_put(8'h22, 1'b0, 1'b0);
    rx_exp.push_back(8'h5A); rx_put(8'h5A, 1'b0, 1'b0);
    status_is("R2 rx count 3", 32'h0040_0003);
    rx_get_check("R5 R14 rx byte 1");
    rx_get_check("R5 R14 rx byte 2");
    rx_get_check("R5 R1 rx byte 3");
    rx_get_check("R5 empty read zero");
    status_is("R5 empty read no change", ST_IDLE);

    // R4 receive overflow
    for (int i = 0; i < 65; i++) rx_put(8'(i), 1'b0, 1'b0);
    status_is("R4 overflow full", 32'h0148_0040);
    bus_write(5'h08, CTL_BASE | B_RXCLR);
    status_is("R6 rx flush keeps sticky", 32'h0150_0000);
    bus_write(5'h08, CTL_BASE | B_ERRCLR);
    status_is("R6 overflow cleared", ST_IDLE);

    // R8 error flags and mask
    rx_put(8'h01, 1'b1, 1'b0);
    status_is("R8 frame error", 32'h0042_0001);
    bus_write(5'h08, CTL_BASE | B_MASK);
    rx_put(8'h02, 1'b0, 1'b1);
    status_is("R8 parity masked", 32'h0042_0002);
    bus_write(5'h08, CTL_BASE | B_ERRCLR | B_RXCLR);
    status_is("R8 cleared", ST_IDLE);

    // R9 receive threshold interrupt
    bus_write(5'h10, 32'hFFFF_0203);
    bus_read(5'h10, d);  chk_eq("R1 thr readback", d, 32'h0000_0203);
    bus_write(5'h08, CTL_BASE | B_RXIE);
    rx_put(8'h31, 1'b0, 1'b0); rx_put(8'h32, 1'b0, 1'b0);
    chk_eq("R9 below threshold", irq_rx, 1'b0);
    rx_put(8'h33, 1'b0, 1'b0);
    chk_eq("R9 at threshold", irq_rx, 1'b1);
    bus_read(5'h04, d);
    chk_eq("R9 after pop", irq_rx, 1'b0);
    bus_write(5'h10, 32'h0000_0200);
    chk_eq("R9 zero threshold", irq_rx, 1'b0);
    bus_write(5'h08, CTL_BASE | B_RXCLR);

    // R10 transmit threshold interrupt
    bus_write(5'h08, CTL_BASE | B_TXIE);
    chk_eq("R10 empty tx", irq_tx, 1'b1);
    tx_put(8'h61, 1'b1); tx_put(8'h62, 1'b1);
    chk_eq("R10 at threshold", irq_tx, 1'b1);
    tx_put(8'h63, 1'b1);
    chk_eq("R10 above threshold", irq_tx, 1'b0);
    bus_write(5'h08, CTL_BASE | B_TXCLR);
    tx_exp.delete();

    // R11 enables gate both directions
    bus_write(5'h08, CTL_BASE & ~32'h0000_3000);
    rx_put(8'h77, 1'b0, 1'b0);
    tx_put(8'h88, 1'b1);
    step(); tx_ready = 1'b1;
    repeat (3) step();
    chk_eq("R11 tx_valid gated", tx_valid, 1'b0);
    status_is("R11 rx ignored tx held", 32'h0010_0100);
    bus_write(5'h08, CTL_BASE);
    repeat (4) step();
    tx_ready = 1'b0;
    chk_eq("R11 tx sent after enable", n_sent, 71 - 67);
    status_is("R11 drained", ST_IDLE);

    // R12 line status inputs
    step();
    line_cts = 1'b1; line_tx_busy = 1'b1; line_rx_busy = 1'b1;
    status_is("R12 line bits", 32'h06D0_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule